// File: doc/BRIEF.md
# Standard-Definition Sync Input Decoder

This block sits at the input of a standard-definition video encoder. It turns the incoming timing information into a small set of clean, registered indications that the rest of the pipeline can use. These are a frame-start pulse, a field-start pulse, the odd/even identity of the current field, a line-start pulse, an active-video flag, a line number within the field and a flag for the lines that may carry vertical-blanking-interval data.

The timing can arrive in one of four ways, chosen by `mode_i`. In mode 0 it is embedded in the 10-bit pixel stream as timing reference codes. In modes 1, 2 and 3 it is carried on discrete pins: an active-low horizontal sync, a pin that is a field flag in modes 1 and 3 and a vertical sync in mode 2, and an optional blanking pin. Which sync edge, taken together with which level of the other sync signal, marks a field or frame boundary depends on the mode. When the blanking pin is switched off, the block derives the blanking from the horizontal sync and its own line count.

The mode, the blanking-pin enable and the standard select are static settings. They are changed only while the block is held in reset.

Top module: `sdsync_dec`

## Requirements
- R1: While `rst_n_i` is low, and in the first sampled cycle after it rises, every output is 0 and `line_o` is 0.
- R2: In mode 0, a timing code is the word sequence 3FFh, 000h, 000h followed by a fourth word. The fourth word carries F in bit 8, V in bit 7 and H in bit 6. A code with H=1 (end of active video) produces a line-start pulse. Pixel values are otherwise ignored.
- R3: In mode 0, a code whose F differs from the F of the previous code gives a field-start pulse. After reset, the previous F counts as 1. F=0 marks an odd field, and that field start is also a frame start. `field_odd_o` changes only at a field start.
- R4: In mode 0, a code with H=0 and V=0 sets `active_o`. A code with H=1 or V=1 clears it. Between codes it holds.
- R5: In mode 1, a toggle of the field pin while HSYNC is low starts a new frame (odd field, frame and field pulses). A toggle while HSYNC is high starts an even field.
- R6: In mode 3, a field-pin toggle while HSYNC is high starts a new frame (odd field). A toggle while HSYNC is low starts an even field.
- R7: In mode 2, falling edges of HSYNC and VSYNC sampled in the same cycle start an odd field and a frame. A VSYNC fall while HSYNC is high starts an even field. A VSYNC fall while HSYNC is already low and not falling starts nothing.
- R8: In modes 1, 2 and 3, each HSYNC falling edge gives a line-start pulse.
- R9: `line_o` becomes 1 at each field start. It then increments by one on each line start and saturates at its maximum.
- R10: In modes 1 to 3 with `blank_en_i`=1, `active_o` follows the blanking pin, where high means active video.
- R11: In modes 1 to 3 with `blank_en_i`=0, `active_o` is HSYNC high and the line number above the field's vertical-blank range. That range is lines 0–21 for 525-line timing and 0–22 for 625-line timing (`pal_i`=1).
- R12: `vbi_o` is high for lines 10–20 in 525-line timing and lines 7–22 in 625-line timing.
- R13: Every output reflects pin values two rising clock edges after they are presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_n_i | input | 1 | Active-low reset |
| mode_i | input | 2 | Timing mode 0..3 |
| blank_en_i | input | 1 | 1: use the blanking pin; 0: derive blanking internally |
| pal_i | input | 1 | 1: 625-line line ranges; 0: 525-line |
| hsync_n_i | input | 1 | Horizontal sync, active low |
| fld_vs_i | input | 1 | Field flag (modes 1, 3) or vertical sync, active low (mode 2) |
| blank_n_i | input | 1 | Blanking pin, high during active video |
| pix_i | input | PIX_W | Pixel bus carrying timing codes in mode 0 |
| frame_start_o | output | 1 | One-cycle pulse at a frame start |
| field_start_o | output | 1 | One-cycle pulse at any field start |
| field_odd_o | output | 1 | 1 while in an odd field |
| line_start_o | output | 1 | One-cycle pulse at a line start |
| active_o | output | 1 | Active-video indication |
| vbi_o | output | 1 | Current line lies in the VBI data range |
| line_o | output | LINE_W | Line number within the field |

## Verification
Each indication is registered twice on its way through the block: once in the input stage and once at the output. A pin change driven just after a falling clock edge therefore appears on the outputs after the second following rising edge. The line number and VBI flag move in that same cycle. The bench keeps a two-deep queue of expected values. At each falling edge it compares the outputs against the entry produced two stimulus steps earlier. Directed checks confirm that a line-start pulse is still absent one edge after an HSYNC fall and present after the second edge.

// File: rtl/sdsync_pkg.sv
`timescale 1ns/1ps
package sdsync_pkg;
   typedef enum logic [1:0] {
      TM_EMBED     = 2'd0,
      TM_FLD_HLOW  = 2'd1,
      TM_HV_EDGE   = 2'd2,
      TM_FLD_HHIGH = 2'd3
   } tmode_e;

   typedef struct packed {
      logic frame;
      logic field;
      logic odd;
      logic line;
   } sync_evt_t;
endpackage

// File: rtl/sdsync_in_stage.sv
`timescale 1ns/1ps
// Registers every timing input once and keeps the previous sync levels for edge detection.
module sdsync_in_stage #(
   parameter int PIX_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             hs_i,
   input  logic             fv_i,
   input  logic             bl_i,
   input  logic [PIX_W-1:0] pix_i,
   output logic             hs_q,
   output logic             hs_p,
   output logic             fv_q,
   output logic             fv_p,
   output logic             bl_q,
   output logic [PIX_W-1:0] pix_q
);
   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         hs_q  <= 1'b1;
         hs_p  <= 1'b1;
         fv_q  <= 1'b1;
         fv_p  <= 1'b1;
         bl_q  <= 1'b0;
         pix_q <= '0;
      end else begin
         hs_q  <= hs_i;
         hs_p  <= hs_q;
         fv_q  <= fv_i;
         fv_p  <= fv_q;
         bl_q  <= bl_i;
         pix_q <= pix_i;
      end
   end
endmodule

// File: rtl/sdsync_trs_parse.sv
`timescale 1ns/1ps
// Finds an all-ones, zero, zero preamble followed by the flag word.
module sdsync_trs_parse #(
   parameter int PIX_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [PIX_W-1:0] pix_q,
   output logic             hit_o,
   output logic             f_o,
   output logic             v_o,
   output logic             h_o
);
   localparam int          PRE_LEN = 3;
   localparam logic [PIX_W-1:0] ONES = {PIX_W{1'b1}};
   localparam int          F_POS   = PIX_W - 2;
   localparam int          V_POS   = PIX_W - 3;
   localparam int          H_POS   = PIX_W - 4;

   logic [PIX_W-1:0] hist [PRE_LEN];

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) hist[0] <= '0;
      else          hist[0] <= pix_q;
   end

   for (genvar gi = 1; gi < PRE_LEN; gi++) begin : g_hist
      always_ff @(posedge clk_i or negedge rst_n_i) begin
         if (!rst_n_i) hist[gi] <= '0;
         else          hist[gi] <= hist[gi-1];
      end
   end

   assign hit_o = (hist[PRE_LEN-1] == ONES) && (hist[1] == '0) && (hist[0] == '0);
   assign f_o   = pix_q[F_POS];
   assign v_o   = pix_q[V_POS];
   assign h_o   = pix_q[H_POS];
endmodule

// File: rtl/sdsync_evt_mux.sv
`timescale 1ns/1ps
// Per-mode decode of which edge/level coincidence marks a field, frame or line.
module sdsync_evt_mux
   import sdsync_pkg::*;
(
   input  tmode_e    mode_i,
   input  logic      hs_q,
   input  logic      hs_p,
   input  logic      fv_q,
   input  logic      fv_p,
   input  logic      trs_hit,
   input  logic      trs_f,
   input  logic      trs_h,
   input  logic      f_last,
   output sync_evt_t evt_o
);
   logic h_fall, v_tog, v_fall;
   assign h_fall = hs_p & ~hs_q;
   assign v_tog  = fv_p ^ fv_q;
   assign v_fall = fv_p & ~fv_q;

   always_comb begin
      evt_o = '0;
      unique case (mode_i)
         TM_EMBED: begin
            evt_o.line = trs_hit & trs_h;
            if (trs_hit && (trs_f != f_last)) begin
               evt_o.field = 1'b1;
               evt_o.frame = ~trs_f;
               evt_o.odd   = ~trs_f;
            end
         end
         TM_FLD_HLOW: begin
            evt_o.line = h_fall;
            if (v_tog) begin
               evt_o.field = 1'b1;
               evt_o.frame = ~hs_q;
               evt_o.odd   = ~hs_q;
            end
         end
         TM_FLD_HHIGH: begin
            evt_o.line = h_fall;
            if (v_tog) begin
               evt_o.field = 1'b1;
               evt_o.frame = hs_q;
               evt_o.odd   = hs_q;
            end
         end
         TM_HV_EDGE: begin
            evt_o.line = h_fall;
            if (v_fall && h_fall) begin
               evt_o.field = 1'b1;
               evt_o.frame = 1'b1;
               evt_o.odd   = 1'b1;
            end else if (v_fall && hs_q) begin
               evt_o.field = 1'b1;
            end
         end
         default: evt_o = '0;
      endcase
   end
endmodule

// File: rtl/sdsync_line_ctr.sv
`timescale 1ns/1ps
// Line-in-field counter with blanking and VBI range decode.
module sdsync_line_ctr #(
   parameter int LINE_W         = 10,
   parameter int NTSC_VB_LAST   = 21,
   parameter int PAL_VB_LAST    = 22,
   parameter int NTSC_VBI_FIRST = 10,
   parameter int NTSC_VBI_LAST  = 20,
   parameter int PAL_VBI_FIRST  = 7,
   parameter int PAL_VBI_LAST   = 22,
   parameter bit SATURATE       = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              pal_i,
   input  logic              fs_i,
   input  logic              ls_i,
   output logic [LINE_W-1:0] line_o,
   output logic              vblank_o,
   output logic              vbi_o
);
   localparam logic [LINE_W-1:0] LMAX   = {LINE_W{1'b1}};
   localparam logic [LINE_W-1:0] ONE    = LINE_W'(1);
   localparam logic [LINE_W-1:0] N_VB   = LINE_W'(NTSC_VB_LAST);
   localparam logic [LINE_W-1:0] P_VB   = LINE_W'(PAL_VB_LAST);
   localparam logic [LINE_W-1:0] N_VI_A = LINE_W'(NTSC_VBI_FIRST);
   localparam logic [LINE_W-1:0] N_VI_B = LINE_W'(NTSC_VBI_LAST);
   localparam logic [LINE_W-1:0] P_VI_A = LINE_W'(PAL_VBI_FIRST);
   localparam logic [LINE_W-1:0] P_VI_B = LINE_W'(PAL_VBI_LAST);

   logic [LINE_W-1:0] inc;

   if (SATURATE) begin : g_sat
      assign inc = (line_o == LMAX) ? LMAX : line_o + ONE;
   end else begin : g_wrap
      assign inc = line_o + ONE;
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)   line_o <= '0;
      else if (fs_i)  line_o <= ONE;
      else if (ls_i)  line_o <= inc;
   end

   assign vblank_o = pal_i ? (line_o <= P_VB) : (line_o <= N_VB);
   assign vbi_o    = pal_i ? ((line_o >= P_VI_A) && (line_o <= P_VI_B))
                           : ((line_o >= N_VI_A) && (line_o <= N_VI_B));
endmodule

// File: rtl/sdsync_dec.sv
`timescale 1ns/1ps
module sdsync_dec
   import sdsync_pkg::*;
#(
   parameter int PIX_W          = 10,
   parameter int LINE_W         = 10,
   parameter int NTSC_VB_LAST   = 21,
   parameter int PAL_VB_LAST    = 22,
   parameter int NTSC_VBI_FIRST = 10,
   parameter int NTSC_VBI_LAST  = 20,
   parameter int PAL_VBI_FIRST  = 7,
   parameter int PAL_VBI_LAST   = 22,
   parameter bit LINE_SATURATE  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic [1:0]        mode_i,
   input  logic              blank_en_i,
   input  logic              pal_i,
   input  logic              hsync_n_i,
   input  logic              fld_vs_i,
   input  logic              blank_n_i,
   input  logic [PIX_W-1:0]  pix_i,
   output logic              frame_start_o,
   output logic              field_start_o,
   output logic              field_odd_o,
   output logic              line_start_o,
   output logic              active_o,
   output logic              vbi_o,
   output logic [LINE_W-1:0] line_o
);
   if (PIX_W < 8) begin : g_chk_pix
      $error("PIX_W must leave room for the F, V and H flag bits");
   end
   if ((PAL_VB_LAST >= (1 << LINE_W)) || (NTSC_VB_LAST >= (1 << LINE_W))) begin : g_chk_line
      $error("LINE_W too narrow for the blanking ranges");
   end

   tmode_e            mode;
   logic              hs_q, hs_p, fv_q, fv_p, bl_q;
   logic [PIX_W-1:0]  pix_q;
   logic              trs_hit, trs_f, trs_v, trs_h;
   logic              f_last;
   logic              vblank;
   sync_evt_t         evt;

   assign mode = tmode_e'(mode_i);

   sdsync_in_stage #(.PIX_W(PIX_W)) u_in (
      .clk_i(clk_i), .rst_n_i(rst_n_i),
      .hs_i(hsync_n_i), .fv_i(fld_vs_i), .bl_i(blank_n_i), .pix_i(pix_i),
      .hs_q(hs_q), .hs_p(hs_p), .fv_q(fv_q), .fv_p(fv_p), .bl_q(bl_q), .pix_q(pix_q)
   );

   sdsync_trs_parse #(.PIX_W(PIX_W)) u_trs (
      .clk_i(clk_i), .rst_n_i(rst_n_i), .pix_q(pix_q),
      .hit_o(trs_hit), .f_o(trs_f), .v_o(trs_v), .h_o(trs_h)
   );

   sdsync_evt_mux u_evt (
      .mode_i(mode), .hs_q(hs_q), .hs_p(hs_p), .fv_q(fv_q), .fv_p(fv_p),
      .trs_hit(trs_hit), .trs_f(trs_f), .trs_h(trs_h), .f_last(f_last),
      .evt_o(evt)
   );

   sdsync_line_ctr #(
      .LINE_W(LINE_W), .NTSC_VB_LAST(NTSC_VB_LAST), .PAL_VB_LAST(PAL_VB_LAST),
      .NTSC_VBI_FIRST(NTSC_VBI_FIRST), .NTSC_VBI_LAST(NTSC_VBI_LAST),
      .PAL_VBI_FIRST(PAL_VBI_FIRST), .PAL_VBI_LAST(PAL_VBI_LAST),
      .SATURATE(LINE_SATURATE)
   ) u_line (
      .clk_i(clk_i), .rst_n_i(rst_n_i), .pal_i(pal_i),
      .fs_i(evt.field), .ls_i(evt.line),
      .line_o(line_o), .vblank_o(vblank), .vbi_o(vbi_o)
   );

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         f_last        <= 1'b1;
         frame_start_o <= 1'b0;
         field_start_o <= 1'b0;
         field_odd_o   <= 1'b0;
         line_start_o  <= 1'b0;
         active_o      <= 1'b0;
      end else begin
         if (trs_hit) f_last <= trs_f;
         frame_start_o <= evt.frame;
         field_start_o <= evt.field;
         line_start_o  <= evt.line;
         if (evt.field) field_odd_o <= evt.odd;
         if (mode == TM_EMBED) begin
            if (trs_hit) active_o <= ~(trs_h | trs_v);
         end else begin
            active_o <= blank_en_i ? bl_q : (hs_q & ~vblank);
         end
      end
   end
endmodule

// File: rtl/sdsync_chk.sv
`timescale 1ns/1ps
module sdsync_chk #(
   parameter int LINE_W = 10
) (
   input logic              clk_i,
   input logic              rst_n_i,
   input logic [1:0]        mode_i,
   input logic              frame_start_o,
   input logic              field_start_o,
   input logic              field_odd_o,
   input logic              line_start_o,
   input logic [LINE_W-1:0] line_o
);
   AST_FRAME_IS_FIELD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      frame_start_o |-> field_start_o); // R3
   AST_FRAME_IS_ODD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      frame_start_o |-> field_odd_o); // R5
   AST_ODD_MOVES_AT_FIELD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (field_odd_o != $past(field_odd_o)) |-> field_start_o); // R3
   AST_LINE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      field_start_o |-> (line_o == LINE_W'(1))); // R9
   AST_LINE_STEP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (line_start_o && !field_start_o && ($past(line_o) != {LINE_W{1'b1}}))
      |-> (line_o == $past(line_o) + 1'b1)); // R9
   AST_HV_FRAME_HAS_LINE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ($stable(mode_i) && (mode_i == 2'd2) && frame_start_o) |-> line_start_o); // R7
endmodule

bind sdsync_dec sdsync_chk #(.LINE_W(LINE_W)) u_chk (.*);

// File: tb/sdsync_dec_tb.sv
`timescale 1ns/1ps
module sdsync_dec_tb_top;
   localparam int CLK_PERIOD_NS = 10;
   localparam int PIX_W  = 10;
   localparam int LINE_W = 10;
   localparam int LMAX   = (1 << LINE_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode = 2'd0;
   logic blank_en = 1'b0, pal = 1'b0, hs = 1'b1, vs = 1'b1, bl = 1'b0;
   logic [PIX_W-1:0] pix = '0;
   logic frame_start, field_start, field_odd, line_start, active, vbi;
   logic [LINE_W-1:0] line;

   always #(CLK_PERIOD_NS/2) clk = ~clk;

   sdsync_dec dut_i (
      .clk_i(clk), .rst_n_i(rst_n), .mode_i(mode), .blank_en_i(blank_en), .pal_i(pal),
      .hsync_n_i(hs), .fld_vs_i(vs), .blank_n_i(bl), .pix_i(pix),
      .frame_start_o(frame_start), .field_start_o(field_start), .field_odd_o(field_odd),
      .line_start_o(line_start), .active_o(active), .vbi_o(vbi), .line_o(line)
   );

   int checks = 0, errors = 0;

   typedef struct { bit fr; bit fs; bit odd; bit ls; bit act; bit vbi; int ln; } exp_t;
   exp_t e1, e2;
   bit mh1, mv1, mf, modd, mact;
   logic [PIX_W-1:0] md1, md2, md3;
   int mline;

   function automatic bit in_vblank(int ln); return ln <= (pal ? 22 : 21); endfunction
   function automatic bit in_vbi(int ln);
      return pal ? (ln >= 7 && ln <= 22) : (ln >= 10 && ln <= 20);
   endfunction
   function automatic string evt_tag();
      case (mode) 2'd0: return "R3"; 2'd1: return "R5"; 2'd2: return "R7"; default: return "R6"; endcase
   endfunction

   task automatic chk(string tag, int got, int exp, string what);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, got, exp, $time);
      end
   endtask

   task automatic model_reset();
      exp_t z;
      z = '{fr:0, fs:0, odd:0, ls:0, act:0, vbi:0, ln:0};
      e1 = z; e2 = z;
      mh1 = 1; mv1 = 1; mf = 1; modd = 0; mact = 0; mline = 0;
      md1 = '0; md2 = '0; md3 = '0;
   endtask

   task automatic compare();
      chk(evt_tag(), frame_start, e2.fr, "frame_start");
      chk(evt_tag(), field_start, e2.fs, "field_start");
      chk(evt_tag(), field_odd, e2.odd, "field_odd");
      chk(mode == 0 ? "R2" : "R8", line_start, e2.ls, "line_start");
      chk("R9", line, e2.ln, "line");
      chk(mode == 0 ? "R4" : (blank_en ? "R10" : "R11"), active, e2.act, "active");
      chk("R12", vbi, e2.vbi, "vbi");
   endtask

   // R13: expectation for pins driven now is compared two steps later
   task automatic step(bit h, bit v, bit b, logic [PIX_W-1:0] p);
      exp_t n;
      bit hf, vt, vf, trs, tf, tv, th;
      @(negedge clk);
      compare();
      hf = mh1 & ~h; vt = mv1 ^ v; vf = mv1 & ~v;
      trs = (md3 == 10'h3FF) && (md2 == 0) && (md1 == 0);
      tf = p[8]; tv = p[7]; th = p[6];
      n = '{fr:0, fs:0, odd:modd, ls:0, act:0, vbi:0, ln:0};
      case (mode)
         2'd0: begin
            n.ls = trs & th;
            if (trs && tf != mf) begin n.fs = 1; n.fr = !tf; n.odd = !tf; end
            if (trs) begin mf = tf; mact = !(th | tv); end
            n.act = mact;
         end
         2'd1: begin n.ls = hf; if (vt) begin n.fs = 1; n.fr = !h; n.odd = !h; end end
         2'd3: begin n.ls = hf; if (vt) begin n.fs = 1; n.fr = h; n.odd = h; end end
         default: begin
            n.ls = hf;
            if (vf && hf) begin n.fs = 1; n.fr = 1; n.odd = 1; end
            else if (vf && h) begin n.fs = 1; n.odd = 0; end
         end
      endcase
      if (mode != 0) n.act = blank_en ? b : (h & !in_vblank(mline));
      if (n.fs) mline = 1;
      else if (n.ls) mline = (mline == LMAX) ? LMAX : mline + 1;
      n.ln = mline; n.vbi = in_vbi(mline); modd = n.odd;
      mh1 = h; mv1 = v; md3 = md2; md2 = md1; md1 = p;
      hs = h; vs = v; bl = b; pix = p;
      e2 = e1; e1 = n;
   endtask

   task automatic apply_reset(logic [1:0] m, bit be, bit pl);
      @(negedge clk);
      rst_n = 0; hs = 1; vs = 1; bl = 0; pix = '0;
      mode = m; blank_en = be; pal = pl;
      repeat (3) @(negedge clk);
      chk("R1", {frame_start, field_start, field_odd, line_start, active, vbi}, 0, "outputs in reset");
      chk("R1", line, 0, "line in reset");
      model_reset();
      rst_n = 1;
   endtask

   task automatic run_pins(int n);
      bit h, v, b;
      h = 1; v = 1; b = 0;
      for (int i = 0; i < n; i++) begin
         if ($urandom % 16 == 0) begin h = ~h; v = ~v; end
         else begin
            if ($urandom % 4 == 0) h = ~h;
            if ($urandom % 200 == 0) v = ~v;
         end
         if ($urandom % 4 == 0) b = ~b;
         step(h, v, b, PIX_W'($urandom));
      end
   endtask

   task automatic run_embed(int n);
      int idx; bit f, fv, fh;
      logic [PIX_W-1:0] w;
      idx = 0; f = 1;
      for (int i = 0; i < n; i++) begin
         case (idx)
            0: if ($urandom % 12 == 0) begin w = 10'h3FF; idx = 1; end
               else w = PIX_W'(4 + ($urandom % 1016));
            1, 2: begin w = '0; idx++; end
            default: begin
               if ($urandom % 4 == 0) f = ~f;
               fv = ($urandom % 3 == 0); fh = $urandom % 2;
               w = {1'b1, f, fv, fh, 6'($urandom)};
               idx = 0;
            end
         endcase
         step($urandom % 2, $urandom % 2, $urandom % 2, w);
      end
   endtask

   initial begin
      #(CLK_PERIOD_NS * 190000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      // directed mode 2 corners
      apply_reset(2'd2, 1'b1, 1'b0);
      step(0, 1, 0, '0);                        // HSYNC fall
      step(0, 1, 0, '0);
      chk("R13", line_start, 0, "line_start one edge after fall");
      step(0, 0, 0, '0);                        // VSYNC fall, HSYNC held low
      chk("R13", line_start, 1, "line_start two edges after fall");
      step(0, 0, 0, '0);
      step(1, 0, 0, '0);
      chk("R7", field_start, 0, "VSYNC fall with HSYNC low");
      step(1, 1, 0, '0);
      step(0, 0, 0, '0);                        // coincident falls
      step(0, 0, 0, '0);
      step(0, 0, 0, '0);
      chk("R7", frame_start, 1, "coincident fall frame");
      chk("R7", field_odd, 1, "coincident fall odd");
      step(1, 0, 0, '0);
      step(1, 1, 0, '0);
      step(1, 0, 0, '0);                        // VSYNC fall, HSYNC high
      step(1, 0, 0, '0);
      step(1, 0, 0, '0);
      chk("R7", field_start, 1, "even field start");
      chk("R7", field_odd, 0, "even field identity");
      run_pins(1500);
      for (int s = 0; s < 8; s++) begin
         apply_reset(2'(s), s[2], $urandom % 2);
         if (s % 4 == 0) run_embed(2500);
         else run_pins(2500);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule